// File: doc/BRIEF.md
# Multi-Sensor Temperature Threshold Interrupt Unit

This block keeps the most recent temperature sample for each of up to sixteen sensors. It compares every sample against three thresholds per sensor: a lower, an upper and a critical one. Each comparison that trips sets a sticky status bit. Every status bit has its own mask bit and its own clear bit. The unmasked upper and lower events are merged onto one level interrupt line. The unmasked critical events drive a second level line. A three-bit enable field gates each event type.

Samples arrive on a strobed input that carries a sensor index and a signed value. A flat register port is used to program the thresholds, masks, clears and enable field, and to read back stored values and status. Temperatures and thresholds are signed fixed-width values in tenths of a degree, and they read back sign-extended to 32 bits. Each sensor also has a valid flag. This flag is low for a fixed number of cycles after each new sample, so software can tell when a reading is settled.

Register address: `reg_addr[7:4]` selects the group and `reg_addr[3:0]` selects the sensor. The groups are:

- 0: stored sample, read only.
- 1: lower threshold.
- 2: upper threshold.
- 3: critical threshold.
- 4: per-sensor control. Write bits: [0] lower mask, [1] upper mask, [2] critical mask, [4] lower clear, [5] upper clear, [6] critical clear. Read returns those bits plus: [8] lower status, [9] upper status, [10] critical status, [12] valid.
- 5: enable field, at sensor index 0. Bit 0 gates lower events, bit 1 gates upper events, bit 2 gates critical events.

Reads are combinational.

Top module: `thermal_trip_unit`

## Requirements
- R1: After reset, both interrupt lines are low and all valid flags are low. The enable field reads 0. Each control register reads 0x7: all masks set, no clears, no status. Lower thresholds read -2048 (0xFFFFF800), and upper and critical thresholds read 2047.
- R2: A sample strobe stores the value for the indexed sensor on that clock edge. Group 0 then reads the value sign-extended to 32 bits.
- R3: A sensor's valid flag is low in the 6 cycles that follow the edge that stores a sample, and high from the 6th edge after it onward.
- R4: One edge after the stored sample meets a condition, the matching status bit sets. The conditions are: upper when sample ≥ upper threshold, lower when sample ≤ lower threshold, and critical when sample ≥ critical threshold. Equality counts as a trip. A critical sample one below its threshold sets no critical status.
- R5: A status bit stays set after the sample returns inside the limits, until it is cleared.
- R6: While a clear bit is 1, its status bit is held at 0 from the next edge on, even if the condition is true. After the clear bit is written back to 0, the status can set again.
- R7: A mask bit of 1 keeps that status out of its interrupt line. The status itself still sets and reads back.
- R8: The upper/lower line is the OR over all sensors of (lower status AND NOT lower mask AND enable bit 0) OR (upper status AND NOT upper mask AND enable bit 1). The critical line is the OR over sensors of critical status AND NOT critical mask AND enable bit 2. Writing 0 to the enable field drops both lines.
- R9: Critical events never drive the upper/lower line, and upper/lower events never drive the critical line. A line stays high while any one sensor still contributes to it.
- R10: Thresholds take the low 12 bits of the write data and read back sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe |
| smp_idx | input | 4 | Sensor index of the sample |
| smp_val | input | 12 | Signed sample in 0.1 °C |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address {group, sensor} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_uplow | output | 1 | Level interrupt for upper/lower events |
| irq_crit | output | 1 | Level interrupt for critical events |
| sns_valid | output | 16 | Per-sensor valid flags |

## Verification
The hardest case to reach is the clear window. The status must stay at zero while its trip condition remains true and a fresh sample lands during the window. It must then set again as soon as the clear bit returns to 0. The stimulus first sets an upper event and then raises the clear bit. A new over-threshold sample is written while the clear bit is held. The bench then lowers the clear bit and watches the status and interrupt come back one edge later. The enable gating and the cross-sensor OR are reached by holding two sensors in critical at once. One of them is then cleared while the other keeps the line up.

// File: rtl/thermal_trip_pkg.sv
// Package: shared constants for the threshold interrupt unit.
// Assumes the register address is {group[3:0], sensor index}.
package thermal_trip_pkg;
    // event kinds, used as bit positions in mask/clear/status triples
    localparam int KIND_LO = 0;
    localparam int KIND_UP = 1;
    localparam int KIND_CR = 2;
    localparam int NUM_KINDS = 3;

    // register groups decoded from the upper address nibble
    typedef enum logic [3:0] {
        GRP_TEMP = 4'd0,
        GRP_LO   = 4'd1,
        GRP_UP   = 4'd2,
        GRP_CR   = 4'd3,
        GRP_CTRL = 4'd4,
        GRP_EN   = 4'd5
    } reg_grp_e;

    // control register field positions
    localparam int CTRL_MASK_LSB = 0;
    localparam int CTRL_CLR_LSB  = 4;
    localparam int CTRL_STS_LSB  = 8;
    localparam int CTRL_VLD_BIT  = 12;
endpackage

// File: rtl/thermal_sensor_slot.sv
// Module: thermal_sensor_slot
// Holds one sensor's sample, three thresholds, masks, clears and sticky
// status, and its valid-flag timer. Assumes writes are single-cycle pulses
// and that thresholds are signed values of TEMP_W bits.
module thermal_sensor_slot
    import thermal_trip_pkg::*;
#(
    parameter int TEMP_W     = 12,
    parameter int VALID_HOLD = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_we,
    input  logic [TEMP_W-1:0]    smp_val,
    input  logic                 wr_lo,
    input  logic                 wr_up,
    input  logic                 wr_cr,
    input  logic                 wr_ctrl,
    input  logic [31:0]          wdata,
    output logic [TEMP_W-1:0]    temp_q,
    output logic [TEMP_W-1:0]    lo_q,
    output logic [TEMP_W-1:0]    up_q,
    output logic [TEMP_W-1:0]    cr_q,
    output logic [NUM_KINDS-1:0] mask_q,
    output logic [NUM_KINDS-1:0] clr_q,
    output logic [NUM_KINDS-1:0] sts_q,
    output logic                 valid
);
    localparam int CNT_W = $clog2(VALID_HOLD + 1);
    localparam logic [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};
    localparam logic [TEMP_W-1:0] T_MAX = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [CNT_W-1:0]  HOLD  = CNT_W'(VALID_HOLD);

    logic [CNT_W-1:0]     hold_cnt;
    logic                 seen_q;
    logic [NUM_KINDS-1:0] hit;

    // sample register
    always_ff @(posedge clk) begin
        if (!rst_n)      temp_q <= '0;
        else if (smp_we) temp_q <= smp_val;
    end

    // threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= T_MIN;
            up_q <= T_MAX;
            cr_q <= T_MAX;
        end else begin
            if (wr_lo) lo_q <= wdata[TEMP_W-1:0];
            if (wr_up) up_q <= wdata[TEMP_W-1:0];
            if (wr_cr) cr_q <= wdata[TEMP_W-1:0];
        end
    end

    // mask and clear bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            clr_q  <= '0;
        end else if (wr_ctrl) begin
            mask_q <= wdata[CTRL_MASK_LSB +: NUM_KINDS];
            clr_q  <= wdata[CTRL_CLR_LSB  +: NUM_KINDS];
        end
    end

    // threshold comparisons on the stored sample
    always_comb begin
        hit[KIND_LO] = $signed(temp_q) <= $signed(lo_q);
        hit[KIND_UP] = $signed(temp_q) >= $signed(up_q);
        hit[KIND_CR] = $signed(temp_q) >= $signed(cr_q);
    end

    // sticky status, held at zero while its clear bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q | hit) & ~clr_q;
    end

    // valid timer: reloads on each sample, counts down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            seen_q   <= 1'b0;
        end else if (smp_we) begin
            hold_cnt <= HOLD;
            seen_q   <= 1'b1;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign valid = seen_q && (hold_cnt == '0);

    // R6
    clear_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q[KIND_UP] |=> !sts_q[KIND_UP]);
    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[KIND_CR] && !clr_q[KIND_CR]) |=> sts_q[KIND_CR]);
    // R3
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_we |=> !valid);
endmodule

// File: rtl/thermal_irq_combine.sv
// Module: thermal_irq_combine
// Folds per-sensor status and mask triples into the two level interrupt
// lines, gated by the enable field. Assumes inputs are registered upstream.
module thermal_irq_combine
    import thermal_trip_pkg::*;
#(
    parameter int NUM_SENSORS = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_SENSORS-1:0][NUM_KINDS-1:0]  sts,
    input  logic [NUM_SENSORS-1:0][NUM_KINDS-1:0]  mask,
    input  logic [NUM_KINDS-1:0]                   en,
    output logic                                   irq_uplow,
    output logic                                   irq_crit
);
    logic [NUM_SENSORS-1:0] ul_req;
    logic [NUM_SENSORS-1:0] cr_req;

    // per-sensor contribution to each line
    for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_req
        assign ul_req[s] = (sts[s][KIND_LO] & ~mask[s][KIND_LO] & en[KIND_LO])
                         | (sts[s][KIND_UP] & ~mask[s][KIND_UP] & en[KIND_UP]);
        assign cr_req[s] =  sts[s][KIND_CR] & ~mask[s][KIND_CR] & en[KIND_CR];
    end

    assign irq_uplow = |ul_req;
    assign irq_crit  = |cr_req;

    // R8
    uplow_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_uplow |-> (en[KIND_LO] || en[KIND_UP]));
    // R9
    crit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> en[KIND_CR]);
endmodule

// File: rtl/thermal_trip_unit.sv
// Module: thermal_trip_unit
// Top of the threshold interrupt unit: decodes the register port, routes
// samples to one slot per sensor, muxes read data and drives the two
// interrupt lines. Assumes NUM_SENSORS is a power of two, at least 2.
module thermal_trip_unit
    import thermal_trip_pkg::*;
#(
    parameter int NUM_SENSORS = 16,
    parameter int TEMP_W      = 12,
    parameter int VALID_HOLD  = 6,
    localparam int IDX_W      = $clog2(NUM_SENSORS),
    localparam int ADDR_W     = 4 + IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_stb,
    input  logic [IDX_W-1:0]       smp_idx,
    input  logic [TEMP_W-1:0]      smp_val,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   irq_uplow,
    output logic                   irq_crit,
    output logic [NUM_SENSORS-1:0] sns_valid
);
    logic [TEMP_W-1:0] temp_a [NUM_SENSORS];
    logic [TEMP_W-1:0] lo_a   [NUM_SENSORS];
    logic [TEMP_W-1:0] up_a   [NUM_SENSORS];
    logic [TEMP_W-1:0] cr_a   [NUM_SENSORS];
    logic [NUM_SENSORS-1:0][NUM_KINDS-1:0] mask_a, clr_a, sts_a;
    logic [NUM_KINDS-1:0] en_q;

    reg_grp_e         grp;
    logic [IDX_W-1:0] sel;
    logic             en_hit;

    assign grp    = reg_grp_e'(reg_addr[ADDR_W-1:IDX_W]);
    assign sel    = reg_addr[IDX_W-1:0];
    assign en_hit = reg_we && (grp == GRP_EN) && (sel == '0);

    // enable field register
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (en_hit) en_q <= reg_wdata[NUM_KINDS-1:0];
    end

    // one slot per sensor
    for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_slot
        logic hit_s;
        assign hit_s = (sel == IDX_W'(s));
        thermal_sensor_slot #(
            .TEMP_W    (TEMP_W),
            .VALID_HOLD(VALID_HOLD)
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_we  (smp_stb && (smp_idx == IDX_W'(s))),
            .smp_val (smp_val),
            .wr_lo   (reg_we && hit_s && grp == GRP_LO),
            .wr_up   (reg_we && hit_s && grp == GRP_UP),
            .wr_cr   (reg_we && hit_s && grp == GRP_CR),
            .wr_ctrl (reg_we && hit_s && grp == GRP_CTRL),
            .wdata   (reg_wdata),
            .temp_q  (temp_a[s]),
            .lo_q    (lo_a[s]),
            .up_q    (up_a[s]),
            .cr_q    (cr_a[s]),
            .mask_q  (mask_a[s]),
            .clr_q   (clr_a[s]),
            .sts_q   (sts_a[s]),
            .valid   (sns_valid[s])
        );
    end

    thermal_irq_combine #(
        .NUM_SENSORS(NUM_SENSORS)
    ) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts      (sts_a),
        .mask     (mask_a),
        .en       (en_q),
        .irq_uplow(irq_uplow),
        .irq_crit (irq_crit)
    );

    // sign extension of a stored temperature field to 32 bits
    function automatic logic [31:0] sext(input logic [TEMP_W-1:0] v);
        return {{(32-TEMP_W){v[TEMP_W-1]}}, v};
    endfunction

    // read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (grp)
            GRP_TEMP: reg_rdata = sext(temp_a[sel]);
            GRP_LO:   reg_rdata = sext(lo_a[sel]);
            GRP_UP:   reg_rdata = sext(up_a[sel]);
            GRP_CR:   reg_rdata = sext(cr_a[sel]);
            GRP_CTRL: begin
                reg_rdata[CTRL_MASK_LSB +: NUM_KINDS] = mask_a[sel];
                reg_rdata[CTRL_CLR_LSB  +: NUM_KINDS] = clr_a[sel];
                reg_rdata[CTRL_STS_LSB  +: NUM_KINDS] = sts_a[sel];
                reg_rdata[CTRL_VLD_BIT]               = sns_valid[sel];
            end
            GRP_EN:   reg_rdata[NUM_KINDS-1:0] = (sel == '0) ? en_q : '0;
            default:  reg_rdata = '0;
        endcase
    end

    // R8
    enable_off_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_hit && reg_wdata[NUM_KINDS-1:0] == '0) |=> (!irq_uplow && !irq_crit));
endmodule

// File: tb/thermal_trip_unit_tb.sv
// Bench for thermal_trip_unit: directed scenarios, one task each.
module thermal_trip_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [3:0]  smp_idx = '0;
    logic [11:0] smp_val = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_uplow, irq_crit;
    logic [N-1:0] sns_valid;

    int checks = 0;
    int failures = 0;

    thermal_trip_unit dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_idx(smp_idx),
        .smp_val(smp_val), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_uplow(irq_uplow),
        .irq_crit(irq_crit), .sns_valid(sns_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // check helper
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one clock, returning at the falling edge
    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] g, input logic [3:0] s, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = {g, s}; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] g, input logic [3:0] s, output logic [31:0] d);
        reg_addr = {g, s}; #1; d = reg_rdata;
    endtask

    task automatic sample(input logic [3:0] s, input int v);
        smp_stb = 1'b1; smp_idx = s; smp_val = 12'(v);
        tick();
        smp_stb = 1'b0;
    endtask

    function automatic logic [2:0] sts_of(input logic [31:0] c);
        return c[10:8];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_uplow", {31'b0, irq_uplow}, 0);
        chk("R1 irq_crit", {31'b0, irq_crit}, 0);
        chk("R1 valid", {16'b0, sns_valid}, 0);
        rd(5, 0, d); chk("R1 enable", d, 0);
        rd(4, 7, d); chk("R1 ctrl", d, 32'h7);
        rd(1, 3, d); chk("R1 lower default", d, 32'hFFFFF800);
        rd(2, 3, d); chk("R1 upper default", d, 32'd2047);
        rd(3, 3, d); chk("R1 crit default", d, 32'd2047);
    endtask

    task automatic t_sample_valid();
        logic [31:0] d;
        sample(3, -150);
        rd(0, 3, d); chk("R2 sample readback", d, 32'hFFFFFF6A);
        chk("R3 valid low after sample", {31'b0, sns_valid[3]}, 0);
        for (int i = 1; i < 6; i++) begin
            tick();
            chk("R3 valid low in window", {31'b0, sns_valid[3]}, 0);
        end
        tick();
        chk("R3 valid high after window", {31'b0, sns_valid[3]}, 1);
        rd(4, 3, d); chk("R3 valid in ctrl", {31'b0, d[12]}, 1);
    endtask

    task automatic t_upper_sticky();
        logic [31:0] d;
        wr(1, 2, -100); wr(2, 2, 500); wr(3, 2, 900);
        rd(1, 2, d); chk("R10 lower sign-extended", d, 32'hFFFFFF9C);
        sample(2, 499); tick();
        rd(4, 2, d); chk("R4 upper below threshold", {29'b0, sts_of(d)}, 0);
        sample(2, 500); tick();
        rd(4, 2, d); chk("R4 upper at threshold", {29'b0, sts_of(d)}, 3'b010);
        chk("R7 masked keeps line low", {31'b0, irq_uplow}, 0);
        wr(5, 0, 3); wr(4, 2, 32'h5);
        chk("R8 upper unmasked raises line", {31'b0, irq_uplow}, 1);
        chk("R9 crit line untouched", {31'b0, irq_crit}, 0);
        sample(2, 200); tick();
        chk("R5 upper sticky", {31'b0, irq_uplow}, 1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(4, 2, 32'h25); tick();
        rd(4, 2, d); chk("R6 cleared", {29'b0, sts_of(d)}, 0);
        chk("R6 line low while clear", {31'b0, irq_uplow}, 0);
        sample(2, 600); tick(); tick();
        rd(4, 2, d); chk("R6 held while clear set", {29'b0, sts_of(d)}, 0);
        wr(4, 2, 32'h5); tick();
        rd(4, 2, d); chk("R6 resets after clear released", {29'b0, sts_of(d)}, 3'b010);
        chk("R6 line back", {31'b0, irq_uplow}, 1);
        sample(2, 200); wr(4, 2, 32'h25); tick(); wr(4, 2, 32'h5); tick();
        chk("R6 line low after pulse clear", {31'b0, irq_uplow}, 0);
    endtask

    task automatic t_lower_enable();
        logic [31:0] d;
        sample(2, -100); tick();
        rd(4, 2, d); chk("R4 lower at threshold", {29'b0, sts_of(d)}, 3'b001);
        wr(4, 2, 32'h4);
        wr(5, 0, 2);
        chk("R8 lower gated by enable bit0", {31'b0, irq_uplow}, 0);
        wr(5, 0, 1);
        chk("R8 lower enabled", {31'b0, irq_uplow}, 1);
        sample(2, 100); wr(4, 2, 32'h17); tick(); wr(4, 2, 32'h7); tick();
        chk("R6 lower cleared", {31'b0, irq_uplow}, 0);
    endtask

    task automatic t_critical();
        logic [31:0] d;
        wr(3, 5, 900); wr(3, 6, 900);
        wr(4, 5, 32'h3); wr(4, 6, 32'h3);
        sample(5, 899); tick();
        rd(4, 5, d); chk("R4 crit one below", {29'b0, sts_of(d)}, 0);
        sample(5, 900); sample(6, 1000); tick();
        rd(4, 5, d); chk("R4 crit at threshold", {29'b0, sts_of(d)}, 3'b100);
        wr(5, 0, 3);
        chk("R8 crit gated by enable bit2", {31'b0, irq_crit}, 0);
        wr(5, 0, 7);
        chk("R8 crit enabled", {31'b0, irq_crit}, 1);
        chk("R9 crit does not drive uplow", {31'b0, irq_uplow}, 0);
        sample(5, 0); wr(4, 5, 32'h43); tick(); wr(4, 5, 32'h3); tick();
        chk("R9 other sensor holds line", {31'b0, irq_crit}, 1);
        wr(4, 6, 32'h7);
        chk("R7 crit masked", {31'b0, irq_crit}, 0);
        rd(4, 6, d); chk("R7 status kept under mask", {29'b0, sts_of(d)}, 3'b100);
        wr(4, 6, 32'h3);
        chk("R7 unmask restores line", {31'b0, irq_crit}, 1);
        wr(5, 0, 0);
        chk("R8 enable zero drops crit", {31'b0, irq_crit}, 0);
        rd(5, 0, d); chk("R8 enable readback", d, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sample_valid();
        t_upper_sticky();
        t_clear();
        t_lower_enable();
        t_critical();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule